// File: doc/BRIEF.md
# Receive Subaddress Ping-Pong Buffer Controller

This block manages receive data for a serial command/response bus terminal that keeps two 32-word data blocks per receive or broadcast subaddress. When a command arrives, the terminal's front end fetches the subaddress pointer from its lookup table and passes it in along with the command fields and a per-subaddress mode bit taken from the subaddress control word. The block then turns each incoming data word into a buffer write at the pointer's block base plus the word index.

When a message ends and the end is flagged valid, a subaddress running in ping-pong mode gets its pointer written back with address bit 5 inverted. The next message then fills the other block, and the block that just completed stays untouched for the host to read. An invalid message, a subaddress with the mode turned off, or a transmit command produces no write-back. Transmit commands to such a subaddress still get single-message addressing from the unmodified pointer. If a new command for the same table entry arrives in the cycle the write-back is issued, the block uses the updated pointer and not the stale table value.

Top module: `dbuf_swapper`

## Requirements
- R1: While a receive message is open, each `word_stb` asserts `buf_we` in the same cycle. `buf_addr` is the captured pointer with bits 4:0 replaced by the word index, counting from 0 at the command, and `buf_wdata` equals `word_data`.
- R2: The word index wraps from 31 to 0, so a message longer than 32 words stays inside its 32-word block.
- R3: A valid end of message (`eom_stb` with `eom_ok`=1) on an open receive or broadcast message with `cmd_dbuf_en`=1 produces exactly one `lut_we` pulse in the following cycle. `lut_wdata` is the captured pointer with bit 5 inverted. `lut_idx` has bit 6 = transmit, bit 5 = broadcast and bits 4:0 = subaddress.
- R4: An end of message with `eom_ok`=0 produces no write-back.
- R5: A message whose command had `cmd_dbuf_en`=0 produces no write-back.
- R6: A transmit command never asserts `buf_we` and never produces a write-back, even with `cmd_dbuf_en`=1.
- R7: `word_stb` or `eom_stb` with no open message has no effect on `buf_we` or `lut_we`.
- R8: A command whose table index equals `lut_idx` in a cycle where `lut_we` is high captures `lut_wdata` in place of `cmd_ptr`.
- R9: During and right after reset, `buf_we` and `lut_we` are low.
- R10: A new command that arrives before the previous message ends discards that message: it gets no write-back, and the index restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command accepted; opens a message |
| cmd_tx | input | 1 | Command is transmit |
| cmd_bcst | input | 1 | Command is broadcast |
| cmd_sa | input | 5 | Subaddress |
| cmd_dbuf_en | input | 1 | Ping-pong mode bit from the subaddress control word |
| cmd_ptr | input | 16 | Lookup-table pointer read for this command |
| word_stb | input | 1 | One data word present |
| word_data | input | 16 | Data word |
| eom_stb | input | 1 | End of message |
| eom_ok | input | 1 | Message was valid |
| buf_we | output | 1 | Data buffer write enable |
| buf_addr | output | 16 | Data buffer address |
| buf_wdata | output | 16 | Data buffer write data |
| lut_we | output | 1 | Pointer write-back strobe |
| lut_idx | output | 7 | Table index of the write-back |
| lut_wdata | output | 16 | Toggled pointer |

## Verification
The pointer write-back of one message and the command capture of the next can land in the same cycle. The bench provokes this by issuing a command for the same subaddress in the cycle right after a valid end of message, while its own lookup-table model still holds the stale pointer. The scoreboard expects the following words at the opposite block and a further write-back toggled back again. A design that takes the stale pointer writes into the block the host is meant to be reading, and the scoreboard reports a mismatch.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
   typedef struct packed {
      logic open;
      logic is_tx;
      logic dbuf;
   } ctx_flags_t;
endpackage

// File: rtl/dbuf_ctx.sv
module dbuf_ctx
   import dbuf_pkg::*;
#(
   parameter int PTR_W     = 16,
   parameter int SA_W      = 5,
   parameter bit BCAST_SEP = 1'b1,
   localparam int IDX_W    = SA_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_stb,
   input  logic             cmd_tx,
   input  logic             cmd_bcst,
   input  logic [SA_W-1:0]  cmd_sa,
   input  logic             cmd_dbuf_en,
   input  logic [PTR_W-1:0] cmd_ptr,
   input  logic             close,
   input  logic             fwd_we,
   input  logic [IDX_W-1:0] fwd_idx,
   input  logic [PTR_W-1:0] fwd_ptr,
   output ctx_flags_t       flags,
   output logic [PTR_W-1:0] ptr,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] new_idx;
   logic [PTR_W-1:0] new_ptr;

   generate
      if (BCAST_SEP) begin : g_sep
         assign new_idx = {cmd_tx, cmd_bcst, cmd_sa};
      end else begin : g_shared
         assign new_idx = {cmd_tx, 1'b0, cmd_sa};
      end
   endgenerate

   assign new_ptr = (fwd_we && fwd_idx == new_idx) ? fwd_ptr : cmd_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         ptr   <= '0;
         idx   <= '0;
      end else if (cmd_stb) begin
         flags.open  <= 1'b1;
         flags.is_tx <= cmd_tx;
         flags.dbuf  <= cmd_dbuf_en & ~cmd_tx;
         ptr         <= new_ptr;
         idx         <= new_idx;
      end else if (close) begin
         flags.open <= 1'b0;
      end
   end
endmodule

// File: rtl/dbuf_addr.sv
module dbuf_addr
   import dbuf_pkg::*;
#(
   parameter int PTR_W  = 16,
   parameter int DATA_W = 16,
   parameter int BLK_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              word_stb,
   input  logic [DATA_W-1:0] word_data,
   input  ctx_flags_t        flags,
   input  logic [PTR_W-1:0]  ptr,
   output logic              buf_we,
   output logic [PTR_W-1:0]  buf_addr,
   output logic [DATA_W-1:0] buf_wdata
);
   logic [BLK_W-1:0] word_idx;
   logic             word_hit;

   assign word_hit  = word_stb & flags.open;
   assign buf_we    = word_hit & ~flags.is_tx;
   assign buf_addr  = {ptr[PTR_W-1:BLK_W], word_idx};
   assign buf_wdata = word_data;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         word_idx <= '0;
      end else if (word_hit) begin
         word_idx <= word_idx + 1'b1;
      end
   end
endmodule

// File: rtl/dbuf_wb.sv
module dbuf_wb
   import dbuf_pkg::*;
#(
   parameter int PTR_W = 16,
   parameter int IDX_W = 7,
   parameter int TGL   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eom_stb,
   input  logic             eom_ok,
   input  ctx_flags_t       flags,
   input  logic [PTR_W-1:0] ptr,
   input  logic [IDX_W-1:0] idx,
   output logic             lut_we,
   output logic [IDX_W-1:0] lut_idx,
   output logic [PTR_W-1:0] lut_wdata
);
   localparam logic [PTR_W-1:0] FLIP = PTR_W'(1) << TGL;
   logic go;

   assign go = eom_stb & eom_ok & flags.open & flags.dbuf & ~flags.is_tx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lut_we    <= 1'b0;
         lut_idx   <= '0;
         lut_wdata <= '0;
      end else begin
         lut_we <= go;
         if (go) begin
            lut_idx   <= idx;
            lut_wdata <= ptr ^ FLIP;
         end
      end
   end
endmodule

// File: rtl/dbuf_swapper.sv
module dbuf_swapper
   import dbuf_pkg::*;
#(
   parameter int PTR_W     = 16,
   parameter int DATA_W    = 16,
   parameter int SA_W      = 5,
   parameter int BLK_W     = 5,
   parameter bit BCAST_SEP = 1'b1,
   localparam int IDX_W    = SA_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_stb,
   input  logic              cmd_tx,
   input  logic              cmd_bcst,
   input  logic [SA_W-1:0]   cmd_sa,
   input  logic              cmd_dbuf_en,
   input  logic [PTR_W-1:0]  cmd_ptr,
   input  logic              word_stb,
   input  logic [DATA_W-1:0] word_data,
   input  logic              eom_stb,
   input  logic              eom_ok,
   output logic              buf_we,
   output logic [PTR_W-1:0]  buf_addr,
   output logic [DATA_W-1:0] buf_wdata,
   output logic              lut_we,
   output logic [IDX_W-1:0]  lut_idx,
   output logic [PTR_W-1:0]  lut_wdata
);
   generate
      if (BLK_W + 1 >= PTR_W) begin : g_bad_ptr
         $error("dbuf_swapper: PTR_W must exceed BLK_W+1");
      end
      if (SA_W < 1) begin : g_bad_sa
         $error("dbuf_swapper: SA_W must be positive");
      end
   endgenerate

   ctx_flags_t       flags;
   logic [PTR_W-1:0] ptr;
   logic [IDX_W-1:0] idx;

   dbuf_ctx #(.PTR_W(PTR_W), .SA_W(SA_W), .BCAST_SEP(BCAST_SEP)) u_ctx (
      .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_tx(cmd_tx),
      .cmd_bcst(cmd_bcst), .cmd_sa(cmd_sa), .cmd_dbuf_en(cmd_dbuf_en),
      .cmd_ptr(cmd_ptr), .close(eom_stb), .fwd_we(lut_we),
      .fwd_idx(lut_idx), .fwd_ptr(lut_wdata), .flags(flags), .ptr(ptr),
      .idx(idx)
   );

   dbuf_addr #(.PTR_W(PTR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .restart(cmd_stb), .word_stb(word_stb),
      .word_data(word_data), .flags(flags), .ptr(ptr), .buf_we(buf_we),
      .buf_addr(buf_addr), .buf_wdata(buf_wdata)
   );

   dbuf_wb #(.PTR_W(PTR_W), .IDX_W(IDX_W), .TGL(BLK_W)) u_wb (
      .clk(clk), .rst_n(rst_n), .eom_stb(eom_stb), .eom_ok(eom_ok),
      .flags(flags), .ptr(ptr), .idx(idx), .lut_we(lut_we),
      .lut_idx(lut_idx), .lut_wdata(lut_wdata)
   );
endmodule

// File: rtl/dbuf_swapper_chk.sv
module dbuf_swapper_chk #(
   parameter int IDX_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             word_stb,
   input logic             eom_stb,
   input logic             eom_ok,
   input logic             buf_we,
   input logic             lut_we,
   input logic [IDX_W-1:0] lut_idx
);
   a_r3_wb_follows_ok_eom: assert property (@(posedge clk) disable iff (!rst_n)
      lut_we |-> $past(eom_stb && eom_ok));
   a_r4_no_wb_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
      (eom_stb && !eom_ok) |=> !lut_we);
   a_r6_no_tx_wb: assert property (@(posedge clk) disable iff (!rst_n)
      lut_we |-> !lut_idx[IDX_W-1]);
   a_r7_write_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> word_stb);
endmodule

bind dbuf_swapper dbuf_swapper_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .eom_stb(eom_stb),
   .eom_ok(eom_ok), .buf_we(buf_we), .lut_we(lut_we), .lut_idx(lut_idx)
);

// File: tb/sim_dbuf_swapper.sv
module sim_dbuf_swapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_stb = 0, cmd_tx = 0, cmd_bcst = 0, cmd_dbuf_en = 0;
   logic [4:0]  cmd_sa = '0;
   logic [15:0] cmd_ptr = '0;
   logic        word_stb = 0, eom_stb = 0, eom_ok = 0;
   logic [15:0] word_data = '0;
   logic        buf_we, lut_we;
   logic [15:0] buf_addr, buf_wdata, lut_wdata;
   logic [6:0]  lut_idx;

   int tests = 0, fails = 0;
   logic [31:0] exp_buf[$];
   logic [22:0] exp_lut[$];
   logic [15:0] ram [128];
   logic [15:0] model [128];

   always #10 clk = ~clk;

   dbuf_swapper u0 (.*);

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: scoreboard pop/compare
   always @(negedge clk) begin
      if (rst_n && buf_we) begin
         if (exp_buf.size() == 0) chk("R7 unexpected buf_we", {buf_addr, buf_wdata}, 32'hx);
         else chk("R1/R2 buffer write", {buf_addr, buf_wdata}, exp_buf.pop_front());
      end
      if (rst_n && lut_we) begin
         ram[lut_idx] <= lut_wdata;
         if (exp_lut.size() == 0) chk("R4/R5/R6 unexpected write-back", {lut_idx, lut_wdata}, 32'hx);
         else chk("R3 write-back", {9'd0, lut_idx, lut_wdata}, {9'd0, exp_lut.pop_front()});
      end
   end

   // issue one message; close=0 leaves it open (aborted by next command)
   task automatic send(bit tx, bit bc, logic [4:0] sa, bit db, int n, bit ok, bit close, int gap);
      logic [6:0] ix = {tx, bc, sa};
      cmd_stb = 1; cmd_tx = tx; cmd_bcst = bc; cmd_sa = sa; cmd_dbuf_en = db;
      cmd_ptr = ram[ix];
      tick();
      cmd_stb = 0;
      for (int i = 0; i < n; i++) begin
         word_stb = 1; word_data = 16'(ix * 256 + i * 3 + 1);
         if (!tx) exp_buf.push_back({model[ix][15:5], 5'(i), word_data});
         tick();
      end
      word_stb = 0;
      if (close) begin
         eom_stb = 1; eom_ok = ok;
         if (!tx && db && ok) begin
            model[ix] = model[ix] ^ 16'h0020;
            exp_lut.push_back({ix, model[ix]});
         end
         tick();
         eom_stb = 0; eom_ok = 0;
      end
      repeat (gap) tick();
   endtask

   initial begin
      for (int i = 0; i < 128; i++) begin
         ram[i] = 16'(i * 64);
         model[i] = 16'(i * 64);
      end
      ram[3] = 16'h1234; model[3] = 16'h1234;
      repeat (3) tick();
      chk("R9 reset outputs", {30'd0, buf_we, lut_we}, 32'd0);
      rst_n = 1;
      tick();
      chk("R9 after reset", {30'd0, buf_we, lut_we}, 32'd0);

      // R7: stray word and eom with nothing open
      word_stb = 1; eom_stb = 1; eom_ok = 1;
      @(negedge clk);
      chk("R7 idle word", {31'd0, buf_we}, 32'd0);
      tick();
      word_stb = 0; eom_stb = 0; eom_ok = 0;
      @(negedge clk);
      chk("R7 idle eom", {31'd0, lut_we}, 32'd0);
      tick();

      send(0, 0, 5'd3, 1, 4, 1, 1, 2);   // R1 R3 unaligned pointer
      send(0, 0, 5'd3, 1, 3, 1, 1, 2);   // R3 swap back
      send(0, 1, 5'd7, 1, 2, 1, 1, 2);   // R3 broadcast index
      send(0, 0, 5'd9, 1, 5, 0, 1, 2);   // R4 invalid
      send(0, 0, 5'd10, 0, 3, 1, 1, 2);  // R5 mode off
      send(1, 0, 5'd11, 1, 4, 1, 1, 2);  // R6 transmit
      send(0, 0, 5'd12, 1, 34, 1, 1, 2); // R2 wrap
      send(0, 0, 5'd13, 1, 2, 1, 0, 0);  // R10 aborted
      send(0, 0, 5'd13, 1, 2, 1, 1, 2);  // R10 restart at index 0
      send(0, 0, 5'd20, 1, 3, 1, 1, 0);  // R8 back-to-back same index
      send(0, 0, 5'd20, 1, 3, 1, 1, 3);  // R8 uses forwarded pointer
      chk("R8 model bit5 restored", {31'd0, model[20][5]}, 32'd0);
      chk("R1-R10 scoreboard drained buf", exp_buf.size(), 0);
      chk("R3 scoreboard drained lut", exp_lut.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule